// File: doc/BRIEF.md
# Byte-Swapping Data Holding Buffer

This block is the four-byte holding store that sits behind a 16-bit host data register of a serial bus controller. The host puts transmit data in two bytes at a time, or one byte as the last write of a message. The host takes receive data out two bytes at a time. A configuration input selects the byte order of these halfword accesses. Toward the transfer sequencer, the block offers a byte pop port for transmit and a byte push port for receive. Transmit and receive share one 32-bit store, and each has its own byte level.

Bytes for transmit leave from the top of the filled region: the byte written most recently to the low end is popped last. Receive bytes fill upward from byte 0, and the host read drains them from the low end. The block keeps five status flags: single-byte, receive-ready, transmit-ready, transmit-underflow and receive-overrun. Host accesses clear some of them and the sequencer sets others. A read that empties the store while the controller is in master receive mode gives a one-cycle completion pulse.

Top module: `swap_hold_buffer`

## Requirements
- R1: After reset the store is zero, both levels are 0, all five flags are 0 and `drain_ack` is 0.
- R2: When `tx_level` ≤ 2, a halfword write shifts the store up by 16 bits, puts the new halfword in bits 15:0 and adds 2 to `tx_level`. With `big_endian`=1 the halfword goes in unchanged. With `big_endian`=0, `wr_data[7:0]` lands in bits 15:8 and `wr_data[15:8]` lands in bits 7:0.
- R3: When `tx_level` > 2, a halfword or byte write has no effect on the store, the levels or the flags.
- R4: When `tx_level` ≤ 2, a byte write shifts the store up by 8 bits, puts `wr_data[7:0]` in bits 7:0 and adds 1 to `tx_level`.
- R5: `tx_byte` shows store byte number `tx_level`−1 (byte n is bits 8n+7:8n), and shows 0 when `tx_level` is 0. A pop lowers a nonzero `tx_level` by 1. A pop at level 0 is ignored.
- R6: A push with `rx_level` < 4 writes `rx_byte` into byte number `rx_level`, adds 1 to `rx_level` and sets `flag_rrdy`. A push at level 4 is ignored.
- R7: `rd_data` is {byte1, byte0} when `big_endian`=0 and {byte0, byte1} when `big_endian`=1.
- R8: On a read with `rx_level`=1, `flag_single` is set and `rx_level` becomes 0. With `rx_level` ≥ 2 the level drops by 2, and when it was above 2 the store also shifts down by 16 bits with zero fill. With `rx_level`=0 the read leaves the level and the store as they are.
- R9: A read that takes `rx_level` from nonzero to 0 clears `flag_rrdy`. If `master_rx` is 1 during that read, `drain_ack` is 1 for exactly the next cycle.
- R10: Every read clears `flag_rovr`. Every accepted write clears `flag_xudf`, and it also clears `flag_xrdy` when `tx_level` is above 2 after the write.
- R11: `xrdy_set`, `xudf_set` and `rovr_set` set their flags, and `single_clr` clears `flag_single`. When a set and a clear hit the same flag in one cycle, the set wins.
- R12: At most one data operation takes effect per cycle, in this priority order: halfword write, byte write, read, pop, push. Lower-ranked requests in the same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Byte order of host halfword accesses |
| master_rx | input | 1 | Controller is in master receive mode |
| wr16_en | input | 1 | Host halfword write strobe |
| wr8_en | input | 1 | Host byte write strobe |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Host read data (low two bytes, ordered) |
| tx_pop | input | 1 | Sequencer takes one transmit byte |
| tx_byte | output | 8 | Next transmit byte |
| tx_level | output | 3 | Transmit bytes held |
| rx_push | input | 1 | Sequencer delivers one receive byte |
| rx_byte | input | 8 | Receive byte |
| rx_level | output | 3 | Receive bytes held |
| xrdy_set | input | 1 | Sequencer sets transmit-ready |
| xudf_set | input | 1 | Sequencer sets transmit-underflow |
| rovr_set | input | 1 | Sequencer sets receive-overrun |
| single_clr | input | 1 | Clears the single-byte flag |
| flag_single | output | 1 | Odd last receive byte was read |
| flag_rrdy | output | 1 | Receive data ready |
| flag_xrdy | output | 1 | Transmit ready |
| flag_xudf | output | 1 | Transmit underflow |
| flag_rovr | output | 1 | Receive overrun |
| drain_ack | output | 1 | One-cycle pulse: master receive read emptied the store |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a host read and a sequencer set of the overrun flag. The second pair is a host write and a sequencer set of the underflow flag. In each case one side clears a flag and the other sets it. The bench drives both strobes together in directed steps and expects the flag set afterwards. It also drives a halfword write together with a read, and a pop together with a push. It expects only the higher-ranked operation to show in the levels and the store. A long random phase then raises any combination of strobes at once, and a behavioural byte-array model judges every cycle.

// File: rtl/swap_hold_buffer.sv
module swap_hold_buffer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_endian,
  input  logic        master_rx,
  input  logic        wr16_en,
  input  logic        wr8_en,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic [2:0]  tx_level,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  output logic [2:0]  rx_level,
  input  logic        xrdy_set,
  input  logic        xudf_set,
  input  logic        rovr_set,
  input  logic        single_clr,
  output logic        flag_single,
  output logic        flag_rrdy,
  output logic        flag_xrdy,
  output logic        flag_xudf,
  output logic        flag_rovr,
  output logic        drain_ack
);
  logic [31:0] hold;
  logic [2:0]  txl, rxl;

  wire op_w16  = wr16_en;
  wire op_w8   = wr8_en & ~wr16_en;
  wire op_rd   = rd_en & ~wr16_en & ~wr8_en;
  wire op_pop  = tx_pop & ~wr16_en & ~wr8_en & ~rd_en;
  wire op_push = rx_push & ~wr16_en & ~wr8_en & ~rd_en & ~tx_pop;
  wire wr_ok   = (txl <= 3'd2);

  wire [15:0] ins16 = big_endian ? wr_data : {wr_data[7:0], wr_data[15:8]};

  assign rd_data  = big_endian ? {hold[7:0], hold[15:8]} : hold[15:0];
  assign tx_level = txl;
  assign rx_level = rxl;

  always_comb begin
    case (txl)
      3'd1:    tx_byte = hold[7:0];
      3'd2:    tx_byte = hold[15:8];
      3'd3:    tx_byte = hold[23:16];
      3'd4:    tx_byte = hold[31:24];
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold        <= '0;
      txl         <= '0;
      rxl         <= '0;
      flag_single <= 1'b0;
      flag_rrdy   <= 1'b0;
      flag_xrdy   <= 1'b0;
      flag_xudf   <= 1'b0;
      flag_rovr   <= 1'b0;
      drain_ack   <= 1'b0;
    end else begin
      drain_ack <= 1'b0;
      if (single_clr) flag_single <= 1'b0;

      if (op_w16) begin
        if (wr_ok) begin
          hold      <= {hold[15:0], ins16};
          txl       <= txl + 3'd2;
          flag_xudf <= 1'b0;
          if (txl != 3'd0) flag_xrdy <= 1'b0;
        end
      end else if (op_w8) begin
        if (wr_ok) begin
          hold      <= {hold[23:0], wr_data[7:0]};
          txl       <= txl + 3'd1;
          flag_xudf <= 1'b0;
          if (txl == 3'd2) flag_xrdy <= 1'b0;
        end
      end else if (op_rd) begin
        flag_rovr <= 1'b0;
        if (rxl == 3'd1) begin
          flag_single <= 1'b1;
          rxl         <= 3'd0;
          flag_rrdy   <= 1'b0;
          drain_ack   <= master_rx;
        end else if (rxl >= 3'd2) begin
          if (rxl > 3'd2) hold <= {16'h0000, hold[31:16]};
          rxl <= rxl - 3'd2;
          if (rxl == 3'd2) begin
            flag_rrdy <= 1'b0;
            drain_ack <= master_rx;
          end
        end
      end else if (op_pop) begin
        if (txl != 3'd0) txl <= txl - 3'd1;
      end else if (op_push) begin
        if (rxl < 3'd4) begin
          hold[{rxl[1:0], 3'b000} +: 8] <= rx_byte;
          rxl       <= rxl + 3'd1;
          flag_rrdy <= 1'b1;
        end
      end

      if (xrdy_set) flag_xrdy <= 1'b1;
      if (xudf_set) flag_xudf <= 1'b1;
      if (rovr_set) flag_rovr <= 1'b1;
    end
  end

  assert_w16_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16_en && tx_level <= 3'd2) |=> tx_level == $past(tx_level) + 3'd2);

  assert_full_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr16_en || wr8_en) && tx_level > 3'd2) |=> ($stable(tx_level) && $stable(rx_level) && $stable(hold)));

  assert_pop_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pop && tx_level != 3'd0) |=> tx_level == $past(tx_level) - 3'd1);

  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_rd && rx_level == 3'd1) |=> (flag_single && rx_level == 3'd0));

  assert_drain_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ack |-> (!flag_rrdy && rx_level == 3'd0 && $past(rd_en)));

  assert_rovr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rovr_set |=> flag_rovr);
endmodule

// File: tb/sim_swap_hold_buffer.sv
module sim_swap_hold_buffer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b0, master_rx = 1'b0;
  logic wr16_en = 1'b0, wr8_en = 1'b0, rd_en = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
  logic xrdy_set = 1'b0, xudf_set = 1'b0, rovr_set = 1'b0, single_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rx_byte = '0;
  logic [15:0] rd_data;
  logic [7:0]  tx_byte;
  logic [2:0]  tx_level, rx_level;
  logic flag_single, flag_rrdy, flag_xrdy, flag_xudf, flag_rovr, drain_ack;

  int errors = 0, checks = 0, cycles = 0;
  logic [7:0] mb [4];
  int mtx, mrx;
  logic m_single, m_rrdy, m_xrdy, m_xudf, m_rovr, m_drain;

  always #5 clk = ~clk;

  swap_hold_buffer u0 (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
        summary();
      end
    end
  end

  function automatic logic [36:0] expected();
    logic [7:0] tb;
    tb = (mtx == 0) ? 8'h00 : mb[mtx-1];
    return {(big_endian ? {mb[0], mb[1]} : {mb[1], mb[0]}), tb, mtx[2:0], mrx[2:0],
            m_single, m_rrdy, m_xrdy, m_xudf, m_rovr, m_drain};
  endfunction

  task automatic compare(string tag);
    logic [36:0] act, exp_v;
    act = {rd_data, tx_byte, tx_level, rx_level,
           flag_single, flag_rrdy, flag_xrdy, flag_xudf, flag_rovr, drain_ack};
    exp_v = expected();
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic model();
    logic [7:0] nb [4];
    logic emptied;
    nb = mb; m_drain = 1'b0; emptied = 1'b0;
    if (single_clr) m_single = 1'b0;
    if (wr16_en) begin
      if (mtx <= 2) begin
        nb[3] = mb[1]; nb[2] = mb[0];
        nb[1] = big_endian ? wr_data[15:8] : wr_data[7:0];
        nb[0] = big_endian ? wr_data[7:0] : wr_data[15:8];
        mtx += 2; m_xudf = 1'b0;
        if (mtx > 2) m_xrdy = 1'b0;
      end
    end else if (wr8_en) begin
      if (mtx <= 2) begin
        nb[3] = mb[2]; nb[2] = mb[1]; nb[1] = mb[0]; nb[0] = wr_data[7:0];
        mtx += 1; m_xudf = 1'b0;
        if (mtx > 2) m_xrdy = 1'b0;
      end
    end else if (rd_en) begin
      m_rovr = 1'b0;
      if (mrx == 1) begin
        m_single = 1'b1; mrx = 0; emptied = 1'b1;
      end else if (mrx >= 2) begin
        if (mrx > 2) begin nb[0] = mb[2]; nb[1] = mb[3]; nb[2] = 8'h00; nb[3] = 8'h00; end
        mrx -= 2;
        if (mrx == 0) emptied = 1'b1;
      end
      if (emptied) begin m_rrdy = 1'b0; m_drain = master_rx; end
    end else if (tx_pop) begin
      if (mtx > 0) mtx -= 1;
    end else if (rx_push) begin
      if (mrx < 4) begin nb[mrx] = rx_byte; mrx += 1; m_rrdy = 1'b1; end
    end
    if (xrdy_set) m_xrdy = 1'b1;
    if (xudf_set) m_xudf = 1'b1;
    if (rovr_set) m_rovr = 1'b1;
    mb = nb;
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    wr16_en = 1'b0; wr8_en = 1'b0; rd_en = 1'b0; tx_pop = 1'b0; rx_push = 1'b0;
    xrdy_set = 1'b0; xudf_set = 1'b0; rovr_set = 1'b0; single_clr = 1'b0;
    #1 compare(tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mb[i] = 8'h00;
    mtx = 0; mrx = 0;
    {m_single, m_rrdy, m_xrdy, m_xudf, m_rovr, m_drain} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 compare("R1");

    wr16_en = 1; wr_data = 16'h1234; step("R2");
    big_endian = 1; #1 compare("R7");
    wr16_en = 1; wr_data = 16'hABCD; step("R2");
    xudf_set = 1; step("R11");
    wr16_en = 1; wr_data = 16'h5555; step("R3");
    wr8_en = 1; wr_data = 16'h0066; step("R3");
    for (int i = 0; i < 5; i++) begin tx_pop = 1; step("R5"); end
    wr8_en = 1; wr_data = 16'h0077; step("R4");
    wr8_en = 1; wr_data = 16'h0088; step("R4");
    xrdy_set = 1; step("R11");
    wr16_en = 1; wr_data = 16'h9A9B; step("R10");
    for (int i = 0; i < 4; i++) begin tx_pop = 1; step("R5"); end

    rx_push = 1; rx_byte = 8'h11; step("R6");
    rx_push = 1; rx_byte = 8'h22; step("R6");
    rx_push = 1; rx_byte = 8'h33; step("R6");
    rx_push = 1; rx_byte = 8'h44; step("R6");
    rx_push = 1; rx_byte = 8'h55; step("R6");
    big_endian = 0; #1 compare("R7");
    master_rx = 1;
    rovr_set = 1; step("R11");
    rd_en = 1; step("R10");
    rd_en = 1; step("R9");
    #1 compare("R9");
    rd_en = 1; step("R8");
    rx_push = 1; rx_byte = 8'hC3; step("R6");
    rd_en = 1; rovr_set = 1; step("R11");
    single_clr = 1; rd_en = 1; step("R11");
    single_clr = 1; step("R11");
    master_rx = 0;
    rx_push = 1; rx_byte = 8'h5A; step("R6");
    rx_push = 1; rx_byte = 8'hA5; step("R6");
    rd_en = 1; step("R9");
    wr16_en = 1; wr_data = 16'h0F0F; rd_en = 1; step("R12");
    wr16_en = 1; wr_data = 16'h1111; xudf_set = 1; step("R11");
    tx_pop = 1; rx_push = 1; rx_byte = 8'hEE; step("R12");
    wr8_en = 1; wr_data = 16'h0042; rd_en = 1; tx_pop = 1; step("R12");

    for (int n = 0; n < 3000; n++) begin
      wr16_en    = ($urandom_range(0, 7) == 0);
      wr8_en     = ($urandom_range(0, 9) == 0);
      rd_en      = ($urandom_range(0, 4) == 0);
      tx_pop     = ($urandom_range(0, 3) == 0);
      rx_push    = ($urandom_range(0, 2) == 0);
      xrdy_set   = ($urandom_range(0, 9) == 0);
      xudf_set   = ($urandom_range(0, 9) == 0);
      rovr_set   = ($urandom_range(0, 9) == 0);
      single_clr = ($urandom_range(0, 7) == 0);
      wr_data    = 16'($urandom);
      rx_byte    = 8'($urandom);
      if ($urandom_range(0, 31) == 0) big_endian = ~big_endian;
      if ($urandom_range(0, 31) == 0) master_rx = ~master_rx;
      step("R12");
    end
    summary();
  end
endmodule